// File: doc/BRIEF.md
# PCM Serial Stereo Transceiver

This block moves 16-bit audio samples between two 32-entry FIFOs and a pair of serial data pins. A clock generator outside the block supplies a one-cycle bit-clock strobe and a frame-sync strobe. Every frame holds two samples, left first and then right, each sent or received most significant bit first. Software or a DMA engine fills the transmit FIFO through a simple write port and empties the receive FIFO through a read port. The read word carries its own valid flag.

One 19-bit control word configures the block. It has a global enable, an enable per direction that also flushes that direction's FIFO while it is clear, and a timing select per direction. The timing select places the first data bit either on the same bit clock as the sync or on the bit clock after it. Each direction also has a DMA request enable and a 6-bit fill threshold that drive its request line. A 20-bit status word reports both FIFO fill counts with empty, almost-empty, full and almost-full flags. Two one-cycle event outputs mark transmit starvation and receive overrun.

Top module: `pcm_stereo_xcvr`

## Requirements
- R1: `fifo_status` = {tx_count[19:14], tx_empty[13], tx_almost_empty[12], tx_full[11], tx_almost_full[10], rx_count[9:4], rx_empty[3], rx_almost_empty[2], rx_full[1], rx_almost_full[0]}. Empty means count 0, almost-empty means count <= 4, full means count 32, almost-full means count >= 28. After reset the word is 20'h0300C.
- R2: While `ctrl_word[2]` (transmit FIFO enable) is set, each `tx_wr` cycle stores `tx_wdata` in order, and a write to a full FIFO is ignored. While the bit is clear, the transmit FIFO is held empty.
- R3: While the transmitter runs, each frame sends the left sample and then the right sample, 16 bits each, MSB first. `ser_out` changes on bit-clock ticks. With `ctrl_word[4]` clear, the left MSB goes out on the tick that carries `frame_sync`. With the bit set, it goes out on the tick after that. `ser_out` returns to 0 on the first tick after the 32nd bit.
- R4: While the receiver runs, `ser_in` is sampled on 32 consecutive ticks. The first of these is the sync tick when `ctrl_word[3]` is clear, or the tick after it when the bit is set. Each group of 16 bits, MSB first, is pushed into the receive FIFO as one sample. While `ctrl_word[1]` is clear, the receive FIFO is held empty.
- R5: `rx_rword` = {valid[16], data[15:0]} shows the oldest receive sample, and `rx_rd` removes it. When the FIFO is empty, the word reads 17'h0 and a read has no effect.
- R6: If the transmit FIFO is empty at the start of a sample, that sample is sent as zeros and `tx_starve` pulses for one cycle.
- R7: A received sample that finds the receive FIFO full is dropped and `rx_overrun` pulses for one cycle. The stored contents are left unchanged.
- R8: `tx_dma_req` = `ctrl_word[6]` AND transmit FIFO enable AND (tx count <= `ctrl_word[18:13]`).
- R9: `rx_dma_req` = `ctrl_word[5]` AND receive FIFO enable AND (rx count >= `ctrl_word[12:7]`).
- R10: With `ctrl_word[0]` (global enable) clear, no serial activity takes place: `ser_out` stays 0, no sample is popped or pushed, and no event pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_word | input | 19 | Control word (fields in R1 to R10) |
| bit_tick | input | 1 | One-cycle strobe per serial bit clock |
| frame_sync | input | 1 | Frame sync, sampled with `bit_tick` |
| ser_in | input | 1 | Serial receive data |
| ser_out | output | 1 | Serial transmit data |
| tx_wr | input | 1 | Write strobe into the transmit FIFO |
| tx_wdata | input | 16 | Transmit sample |
| rx_rd | input | 1 | Read strobe from the receive FIFO |
| rx_rword | output | 17 | Receive word: valid flag and sample |
| fifo_status | output | 20 | FIFO counts and flags |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_starve | output | 1 | Pulse: a transmit sample was starved |
| rx_overrun | output | 1 | Pulse: a receive sample was dropped |

## Verification
The transmit FIFO is filled one word at a time from empty to past full. At every count the bench compares the flags and the DMA request against their arithmetic definitions, which covers both almost-thresholds and the write that a full FIFO ignores. Serial frames are run in both timing modes and in each direction. A one-tick error in where the MSB sits shows up as a shifted word, and swapped channels show up as a wrong read order. Further frames go to an empty transmit FIFO and to a full receive FIFO to exercise starvation and overrun. A frame is also run with the global enable clear to show that neither FIFO is touched.

// File: rtl/pcmx_pkg.sv
package pcmx_pkg;

    localparam int SAMPLE_W = 16;
    localparam int FRAME_CH = 2;
    localparam int FRAME_BITS = SAMPLE_W * FRAME_CH;
    localparam int CTRL_W = 19;
    localparam int CNT_W = 6;
    localparam int STAT_W = 2 * (CNT_W + 4);

    // control word field positions (decoded by the register neighbour)
    localparam int C_GLOBAL = 0;
    localparam int C_RX_EN = 1;
    localparam int C_TX_EN = 2;
    localparam int C_RX_LATE = 3;
    localparam int C_TX_LATE = 4;
    localparam int C_RX_DMA = 5;
    localparam int C_TX_DMA = 6;
    localparam int C_RX_THR = 7;
    localparam int C_TX_THR = 13;

    typedef struct packed {
        logic             fifo_en;
        logic             msb_late;
        logic             dma_en;
        logic [CNT_W-1:0] thr;
    } lane_cfg_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             empty;
        logic             aempty;
        logic             full;
        logic             afull;
    } fifo_flags_t;

    function automatic lane_cfg_t tx_cfg(input logic [CTRL_W-1:0] w);
        lane_cfg_t c;
        c.fifo_en  = w[C_TX_EN];
        c.msb_late = w[C_TX_LATE];
        c.dma_en   = w[C_TX_DMA];
        c.thr      = w[C_TX_THR +: CNT_W];
        return c;
    endfunction

    function automatic lane_cfg_t rx_cfg(input logic [CTRL_W-1:0] w);
        lane_cfg_t c;
        c.fifo_en  = w[C_RX_EN];
        c.msb_late = w[C_RX_LATE];
        c.dma_en   = w[C_RX_DMA];
        c.thr      = w[C_RX_THR +: CNT_W];
        return c;
    endfunction

    function automatic fifo_flags_t make_flags(input logic [CNT_W-1:0] c,
                                               input int depth,
                                               input int margin);
        fifo_flags_t f;
        int n;
        n = int'(c);
        f.cnt    = c;
        f.empty  = (n == 0);
        f.aempty = (n <= margin);
        f.full   = (n == depth);
        f.afull  = (n >= depth - margin);
        return f;
    endfunction

endpackage

// File: rtl/pcmx_fifo.sv
module pcmx_fifo #(
    parameter int DEPTH = 32,
    parameter int W = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count
);
    logic [W-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic do_push, do_pop;

    assign do_push = push && (count != CW'(DEPTH));
    assign do_pop  = pop && (count != '0);
    assign head    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/pcmx_slot_seq.sv
module pcmx_slot_seq #(
    parameter int FRAME_BITS = 32,
    parameter int SAMPLE_BITS = 16,
    parameter bit MARK_LAST = 1'b0,
    localparam int IW = $clog2(FRAME_BITS),
    localparam int SW = $clog2(SAMPLE_BITS)
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    input  logic sync,
    input  logic late,
    output logic step,
    output logic mark
);
    logic busy, pend, start;
    logic [IW-1:0] cnt, idx;
    localparam logic [SW-1:0] MARK_POS = MARK_LAST ? {SW{1'b1}} : {SW{1'b0}};

    always_comb begin
        start = run && tick && (sync ? !late : pend);
        idx   = start ? '0 : cnt;
        step  = run && tick && (start || busy);
        mark  = step && (idx[SW-1:0] == MARK_POS);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            busy <= 1'b0;
            pend <= 1'b0;
            cnt  <= '0;
        end else if (tick) begin
            pend <= sync && late;
            if (start) begin
                busy <= 1'b1;
                cnt  <= IW'(1);
            end else if (busy) begin
                cnt <= cnt + 1'b1;
                if (cnt == IW'(FRAME_BITS - 1)) busy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pcmx_tx_lane.sv
module pcmx_tx_lane #(
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          tick,
    input  logic          step,
    input  logic          first,
    input  logic [SW-1:0] head,
    input  logic          empty,
    output logic          pop,
    output logic          ser,
    output logic          starve
);
    logic [SW-1:0] sh;

    assign pop = step && first && !empty;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            sh     <= '0;
            ser    <= 1'b0;
            starve <= 1'b0;
        end else begin
            starve <= step && first && empty;
            if (step) begin
                if (first) begin
                    ser <= empty ? 1'b0 : head[SW-1];
                    sh  <= empty ? '0 : {head[SW-2:0], 1'b0};
                end else begin
                    ser <= sh[SW-1];
                    sh  <= {sh[SW-2:0], 1'b0};
                end
            end else if (tick) begin
                ser <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pcmx_rx_lane.sv
module pcmx_rx_lane #(
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          step,
    input  logic          last,
    input  logic          ser_in,
    input  logic          full,
    output logic          push,
    output logic [SW-1:0] pdata,
    output logic          overrun
);
    logic [SW-2:0] sh;

    assign pdata = {sh, ser_in};
    assign push  = step && last;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            sh      <= '0;
            overrun <= 1'b0;
        end else begin
            overrun <= step && last && full;
            if (step) sh <= pdata[SW-2:0];
        end
    end
endmodule

// File: rtl/pcm_stereo_xcvr.sv
module pcm_stereo_xcvr
    import pcmx_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int MARGIN = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CTRL_W-1:0]   ctrl_word,
    input  logic                bit_tick,
    input  logic                frame_sync,
    input  logic                ser_in,
    output logic                ser_out,
    input  logic                tx_wr,
    input  logic [SAMPLE_W-1:0] tx_wdata,
    input  logic                rx_rd,
    output logic [SAMPLE_W:0]   rx_rword,
    output logic [STAT_W-1:0]   fifo_status,
    output logic                tx_dma_req,
    output logic                rx_dma_req,
    output logic                tx_starve,
    output logic                rx_overrun
);
    localparam int FCW = $clog2(DEPTH + 1);
    localparam int DIR_TX = 0;
    localparam int DIR_RX = 1;

    lane_cfg_t   txc, rxc;
    fifo_flags_t txf, rxf;
    logic [1:0]  run_d, late_d, step_d, mark_d;
    logic [FCW-1:0] tx_cnt, rx_cnt;
    logic [SAMPLE_W-1:0] tx_head, rx_head, rx_pdata;
    logic tx_pop, rx_push;

    assign txc = tx_cfg(ctrl_word);
    assign rxc = rx_cfg(ctrl_word);
    assign run_d[DIR_TX]  = ctrl_word[C_GLOBAL] && txc.fifo_en;
    assign run_d[DIR_RX]  = ctrl_word[C_GLOBAL] && rxc.fifo_en;
    assign late_d[DIR_TX] = txc.msb_late;
    assign late_d[DIR_RX] = rxc.msb_late;

    // one bit sequencer per direction; the receive one marks sample ends
    for (genvar d = 0; d < 2; d++) begin : g_seq
        pcmx_slot_seq #(
            .FRAME_BITS (FRAME_BITS),
            .SAMPLE_BITS(SAMPLE_W),
            .MARK_LAST  (d == DIR_RX)
        ) u_seq (
            .clk (clk),
            .rst (rst),
            .run (run_d[d]),
            .tick(bit_tick),
            .sync(frame_sync),
            .late(late_d[d]),
            .step(step_d[d]),
            .mark(mark_d[d])
        );
    end

    pcmx_fifo #(.DEPTH(DEPTH), .W(SAMPLE_W)) u_txq (
        .clk  (clk),
        .rst  (rst),
        .clr  (!txc.fifo_en),
        .push (tx_wr && txc.fifo_en),
        .din  (tx_wdata),
        .pop  (tx_pop),
        .head (tx_head),
        .count(tx_cnt)
    );

    pcmx_fifo #(.DEPTH(DEPTH), .W(SAMPLE_W)) u_rxq (
        .clk  (clk),
        .rst  (rst),
        .clr  (!rxc.fifo_en),
        .push (rx_push),
        .din  (rx_pdata),
        .pop  (rx_rd && rxc.fifo_en),
        .head (rx_head),
        .count(rx_cnt)
    );

    assign txf = make_flags(CNT_W'(tx_cnt), DEPTH, MARGIN);
    assign rxf = make_flags(CNT_W'(rx_cnt), DEPTH, MARGIN);

    pcmx_tx_lane #(.SW(SAMPLE_W)) u_txl (
        .clk   (clk),
        .rst   (rst),
        .run   (run_d[DIR_TX]),
        .tick  (bit_tick),
        .step  (step_d[DIR_TX]),
        .first (mark_d[DIR_TX]),
        .head  (tx_head),
        .empty (txf.empty),
        .pop   (tx_pop),
        .ser   (ser_out),
        .starve(tx_starve)
    );

    pcmx_rx_lane #(.SW(SAMPLE_W)) u_rxl (
        .clk    (clk),
        .rst    (rst),
        .run    (run_d[DIR_RX]),
        .step   (step_d[DIR_RX]),
        .last   (mark_d[DIR_RX]),
        .ser_in (ser_in),
        .full   (rxf.full),
        .push   (rx_push),
        .pdata  (rx_pdata),
        .overrun(rx_overrun)
    );

    assign rx_rword    = {!rxf.empty, rxf.empty ? '0 : rx_head};
    assign fifo_status = {txf, rxf};
    assign tx_dma_req  = txc.dma_en && txc.fifo_en && (txf.cnt <= txc.thr);
    assign rx_dma_req  = rxc.dma_en && rxc.fifo_en && (rxf.cnt >= rxc.thr);
endmodule

// File: rtl/pcmx_checker.sv
module pcmx_checker #(
    parameter int DEPTH = 32
) (
    input logic        clk,
    input logic        rst,
    input logic [18:0] ctrl_word,
    input logic        ser_out,
    input logic [19:0] fifo_status,
    input logic        tx_dma_req,
    input logic        rx_dma_req,
    input logic        tx_starve,
    input logic        rx_overrun
);
    p_count_bound_r1: assert property (@(posedge clk) disable iff (rst)
        (int'(fifo_status[19:14]) <= DEPTH) && (int'(fifo_status[9:4]) <= DEPTH));

    p_flush_tx_r2: assert property (@(posedge clk) disable iff (rst)
        !ctrl_word[2] |=> (fifo_status[19:14] == 6'd0));

    p_flush_rx_r4: assert property (@(posedge clk) disable iff (rst)
        !ctrl_word[1] |=> (fifo_status[9:4] == 6'd0));

    p_starve_empty_r6: assert property (@(posedge clk) disable iff (rst)
        tx_starve |-> $past(fifo_status[13]));

    p_overrun_full_r7: assert property (@(posedge clk) disable iff (rst)
        rx_overrun |-> $past(fifo_status[1]));

    p_txdreq_gate_r8: assert property (@(posedge clk) disable iff (rst)
        tx_dma_req |-> (ctrl_word[6] && ctrl_word[2]));

    p_rxdreq_gate_r9: assert property (@(posedge clk) disable iff (rst)
        rx_dma_req |-> (ctrl_word[5] && ctrl_word[1]));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !ctrl_word[0] |=> (!ser_out && !tx_starve && !rx_overrun));
endmodule

bind pcm_stereo_xcvr pcmx_checker #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ctrl_word  (ctrl_word),
    .ser_out    (ser_out),
    .fifo_status(fifo_status),
    .tx_dma_req (tx_dma_req),
    .rx_dma_req (rx_dma_req),
    .tx_starve  (tx_starve),
    .rx_overrun (rx_overrun)
);

// File: tb/sim_pcm_stereo_xcvr.sv
module sim_pcm_stereo_xcvr;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [18:0] ctrl_word = '0;
    logic        bit_tick = 1'b0, frame_sync = 1'b0, ser_in = 1'b0;
    logic        ser_out;
    logic        tx_wr = 1'b0;
    logic [15:0] tx_wdata = '0;
    logic        rx_rd = 1'b0;
    logic [16:0] rx_rword;
    logic [19:0] fifo_status;
    logic        tx_dma_req, rx_dma_req, tx_starve, rx_overrun;

    int checks = 0, fails = 0, starve_n = 0, ovr_n = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcm_stereo_xcvr u0 (.*);

    always @(negedge clk) begin
        if (!rst) begin
            if (tx_starve) starve_n++;
            if (rx_overrun) ovr_n++;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [18:0] mk(input logic g, rxen, txen, rxl, txl, rxd, txd,
                                       input int rxthr, input int txthr);
        return {6'(txthr), 6'(rxthr), txd, rxd, txl, rxl, txen, rxen, g};
    endfunction

    function automatic logic [9:0] flags(input int c);
        return {6'(c), c == 0, c <= 4, c == 32, c >= 28};
    endfunction

    function automatic logic [15:0] val(input int i);
        return 16'(32'hA5C3 ^ (i * 32'h1D2B));
    endfunction

    task automatic set_ctrl(input logic [18:0] w);
        @(negedge clk) ctrl_word = w;
    endtask

    task automatic wr(input logic [15:0] d);
        @(negedge clk) begin tx_wr = 1'b1; tx_wdata = d; end
        @(negedge clk) tx_wr = 1'b0;
    endtask

    task automatic rd(output logic [16:0] w);
        @(negedge clk) begin w = rx_rword; rx_rd = 1'b1; end
        @(negedge clk) rx_rd = 1'b0;
    endtask

    task automatic do_tick(input logic fs, input logic sdi, output logic so);
        @(negedge clk) begin bit_tick = 1'b1; frame_sync = fs; ser_in = sdi; end
        @(negedge clk) begin bit_tick = 1'b0; frame_sync = 1'b0; so = ser_out; end
        @(negedge clk);
        @(negedge clk);
    endtask

    // 33 ticks from the sync tick; seen[32] is the sync tick
    task automatic frame(input logic [31:0] rxw, input logic rx_late, output logic [32:0] seen);
        for (int t = 0; t < 33; t++) begin
            int b;
            logic so;
            b = t - int'(rx_late);
            do_tick(t == 0, (b >= 0 && b < 32) ? rxw[31-b] : 1'b0, so);
            seen[32-t] = so;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [32:0] seen;
        logic [16:0] w;
        int s0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset status", 32'(fifo_status), 32'h0300C);
        chk("R5 reset read word", 32'(rx_rword), 32'h0);
        chk("R3 reset ser_out", 32'(ser_out), 32'h0);
        chk("R8 reset tx dreq", 32'(tx_dma_req), 32'h0);

        // R1 R2 R8: fill sweep with transmit DMA threshold 10
        set_ctrl(mk(0, 0, 1, 0, 0, 0, 1, 0, 10));
        @(negedge clk);
        chk("R8 dreq at count 0", 32'(tx_dma_req), 32'h1);
        for (int k = 1; k <= 33; k++) begin
            int c;
            wr(val(k));
            c = (k > 32) ? 32 : k;
            chk("R1 tx flags during fill", 32'(fifo_status[19:10]), 32'(flags(c)));
            chk("R8 tx dreq vs count", 32'(tx_dma_req), 32'(c <= 10));
        end
        for (int t = 0; t <= 32; t++) begin
            set_ctrl(mk(0, 0, 1, 0, 0, 0, 1, 0, t));
            @(negedge clk);
            chk("R8 tx dreq threshold sweep at full", 32'(tx_dma_req), 32'(t == 32));
        end
        set_ctrl(mk(0, 0, 1, 0, 0, 0, 0, 0, 32));
        @(negedge clk);
        chk("R8 dreq off without dma enable", 32'(tx_dma_req), 32'h0);
        set_ctrl('0);
        @(negedge clk);
        chk("R2 flush on enable clear", 32'(fifo_status), 32'h0300C);

        // R3 R6: transmit frames in both timing modes
        for (int late = 0; late < 2; late++) begin
            logic [15:0] a, b;
            a = val(40 + late);
            b = val(50 + late);
            set_ctrl(mk(1, 0, 1, 0, late[0], 0, 0, 0, 0));
            wr(a);
            wr(b);
            s0 = starve_n;
            frame('0, 1'b0, seen);
            if (late == 0) begin
                chk("R3 tx frame, MSB on sync tick", seen[32:1], {a, b});
                chk("R3 tx idle after frame", 32'(seen[0]), 32'h0);
            end else begin
                chk("R3 tx frame, MSB after sync", seen[31:0], {a, b});
                chk("R3 tx quiet on sync tick", 32'(seen[32]), 32'h0);
            end
            chk("R6 no starve with data", 32'(starve_n - s0), 32'h0);
            chk("R3 tx fifo drained", 32'(fifo_status[19:14]), 32'h0);
            frame('0, 1'b0, seen);
            chk("R6 starved frame is zeros", 32'(seen != '0), 32'h0);
            chk("R6 two starve pulses", 32'(starve_n - s0), 32'h2);
            set_ctrl('0);
        end

        // R4 R5: receive frames in both timing modes
        for (int late = 0; late < 2; late++) begin
            logic [15:0] c, d;
            c = val(60 + late);
            d = val(70 + late);
            set_ctrl(mk(1, 1, 0, late[0], 0, 0, 0, 0, 0));
            frame({c, d}, late[0], seen);
            chk("R4 rx flags after frame", 32'(fifo_status[9:0]), 32'(flags(2)));
            rd(w);
            chk("R4 R5 rx left sample", 32'(w), 32'({1'b1, c}));
            rd(w);
            chk("R4 R5 rx right sample", 32'(w), 32'({1'b1, d}));
            rd(w);
            chk("R5 empty read word", 32'(w), 32'h0);
            @(negedge clk);
            chk("R5 empty read keeps count", 32'(fifo_status[9:0]), 32'(flags(0)));
            set_ctrl('0);
        end

        // R7 R9: fill receive FIFO, overflow, drain with threshold 20
        set_ctrl(mk(1, 1, 0, 0, 0, 1, 0, 20, 0));
        for (int f = 0; f < 16; f++) frame({val(2*f), val(2*f+1)}, 1'b0, seen);
        chk("R1 rx full flags", 32'(fifo_status[9:0]), 32'(flags(32)));
        chk("R7 no overrun yet", 32'(ovr_n), 32'h0);
        frame({val(90), val(91)}, 1'b0, seen);
        chk("R7 two overrun pulses", 32'(ovr_n), 32'h2);
        chk("R7 count held at full", 32'(fifo_status[9:4]), 32'd32);
        for (int i = 0; i < 32; i++) begin
            chk("R9 rx dreq vs count", 32'(rx_dma_req), 32'((32 - i) >= 20));
            rd(w);
            chk("R7 stored order kept", 32'(w), 32'({1'b1, val(i)}));
        end
        chk("R9 rx dreq at empty", 32'(rx_dma_req), 32'h0);
        set_ctrl('0);

        // R10: global enable clear
        set_ctrl(mk(0, 1, 1, 0, 0, 0, 0, 0, 0));
        wr(val(99));
        s0 = starve_n;
        frame({val(1), val(2)}, 1'b0, seen);
        chk("R10 ser_out quiet", 32'(seen != '0), 32'h0);
        chk("R10 tx not popped", 32'(fifo_status[19:10]), 32'(flags(1)));
        chk("R10 rx not pushed", 32'(fifo_status[9:0]), 32'(flags(0)));
        chk("R10 no events", 32'(starve_n - s0), 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule